// File: doc/BRIEF.md
# Sequential-Access One-Time-Programmable Byte Array

This block models the device side of a one-time-programmable byte store that has no address bus. A single internal counter selects the cell. A clear input sends the counter back to zero, and each rising edge on a step input moves it forward by one. The only way to revisit an earlier cell is to clear and count forward again. The usable span is chosen by a two-bit size input: 512 bytes, 1 KB, 2 KB or 4 KB.

Reading is controlled by an active-low output enable. While it is low, the byte at the counter position appears on the data output and the bus driver enable is raised. While it is high, the bus is released. Programming is controlled by an active-low program strobe. The data bus value is captured when the strobe falls. When the strobe rises again, that value is ANDed into the selected cell. An erased cell reads FFh, and a written bit can never return to 1.

All inputs are sampled on `clk_i`. Clear, step and strobe edges are recognised from one sampled level to the next.

Top module: `otp_seq_array`

## Requirements
- R1: When `clear_i` is high at a clock edge, the counter becomes 0 after that edge. Clear takes priority over a step seen at the same edge.
- R2: A step is recognised when `step_i` is low at one edge and high at the next. Each recognised step advances the counter by one after that edge. Holding `step_i` high advances the counter only once.
- R3: A recognised step from the last address of the selected size, or from any higher address, sets the counter to 0. The last addresses are 1FFh, 3FFh, 7FFh and FFFh for `size_sel_i` values 0, 1, 2 and 3.
- R4: `data_oe_o` equals the inverse of `oe_ni` in the same cycle. While `oe_ni` is high, `data_o` is 00h.
- R5: While `oe_ni` is low, `data_o` carries the stored byte at the current counter position, with bit n of the output equal to bit n of the byte.
- R6: `data_i` is captured at the first edge where `pgm_ni` is seen low. At the first edge where `pgm_ni` is seen high again, the byte at the current counter position becomes its old value ANDed with the captured value. The new value is visible after that edge. Changes on `data_i` while the strobe is held low have no effect.
- R7: No stored bit ever changes from 0 to 1. Programming a cell with FFh leaves it unchanged.
- R8: Stored contents are kept across clears, steps and size changes. Clearing and counting forward to a cell reads back its earlier value.
- R9: Asserting `rst_ni` low asynchronously sets the counter to 0 and every cell to FFh. The step tracker becomes idle-low and the strobe tracker becomes idle-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Counter clear, active high |
| step_i | input | 1 | Counter advance on its rising edge |
| oe_ni | input | 1 | Read enable, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| size_sel_i | input | 2 | Array span: 0=512 B, 1=1 KB, 2=2 KB, 3=4 KB |
| data_i | input | 8 | Bus value to be programmed |
| data_o | output | 8 | Read data, 00h while released |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
Counter moves and cell writes are registered. Their effect appears in the cycle after the edge that sampled clear, step or strobe release. The bus enable and read data follow `oe_ni` and the counter combinationally in the same cycle. The bench changes inputs 1 ns after each rising edge and compares all outputs at the falling edge. A behavioural reference, keyed by address in an associative array, advances on the same rising edges, so every expected value already includes the one-edge latency of the registered paths.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SPAN_512 = 2'd0,
    SPAN_1K  = 2'd1,
    SPAN_2K  = 2'd2,
    SPAN_4K  = 2'd3
  } span_e;

  // last index of a span, the largest span being 2**aw cells
  function automatic int unsigned span_last(int unsigned aw, span_e sel);
    return (32'd1 << (aw - 3 + int'(sel))) - 1;
  endfunction
endpackage

// File: rtl/otp_edge_det.sv
module otp_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  localparam logic IDLE = ~RISING;
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= IDLE;
    else         sig_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~sig_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & sig_q;
    end
  endgenerate
endmodule

// File: rtl/otp_addr_ctr.sv
module otp_addr_ctr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (adv_i) begin
      if (cnt_q >= last_i)      cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign addr_o = cnt_q;
endmodule

// File: rtl/otp_byte_array.sv
module otp_byte_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wval_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_i) begin
      // one-way: only clears bits
      mem_q[addr_i] <= mem_q[addr_i] & wval_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/otp_seq_array.sv
module otp_seq_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic [1:0]        size_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              step_rise;
  logic              pgm_fall;
  logic              pgm_rise;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wval_q;
  logic [DATA_W-1:0] rdata;

  assign last_addr = ADDR_W'(span_last(ADDR_W, span_e'(size_sel_i)));

  otp_edge_det #(.RISING(1'b1)) u_step_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(step_i), .edge_o(step_rise)
  );
  // strobe is active low: its fall starts, its release ends a pulse
  otp_edge_det #(.RISING(1'b0)) u_pgm_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(pgm_ni), .edge_o(pgm_fall)
  );
  otp_edge_det #(.RISING(1'b1)) u_pgm_end (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(pgm_ni), .edge_o(pgm_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wval_q <= '1;
    else if (pgm_fall) wval_q <= data_i;
  end

  otp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .adv_i  (step_rise),
    .last_i (last_addr),
    .addr_o (addr_q)
  );

  otp_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_q),
    .wr_i   (pgm_rise),
    .wval_i (wval_q),
    .rdata_o(rdata)
  );

  assign data_oe_o = ~oe_ni;
  assign data_o    = oe_ni ? '0 : rdata;
endmodule

// File: rtl/otp_seq_array_chk.sv
module otp_seq_array_chk
  import otp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              step_i,
  input logic              oe_ni,
  input logic [1:0]        size_sel_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [ADDR_W-1:0] addr_q
);
  logic seen_q;
  logic step_d;
  logic adv;
  logic [ADDR_W-1:0] lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      step_d <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      step_d <= step_i;
    end
  end

  assign adv = step_i & ~step_d;
  assign lim = ADDR_W'(span_last(ADDR_W, span_e'(size_sel_i)));

  // R1
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> addr_q == '0);

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && adv && addr_q < lim) |=> addr_q == $past(addr_q) + 1'b1);

  // R3
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && adv && addr_q >= lim) |=> addr_q == '0);

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !adv) |=> $stable(addr_q));

  // R4
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!data_oe_o && data_o == '0));

  // R7
  no_set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !oe_ni && !$past(oe_ni) && $stable(addr_q))
      |-> (data_o & ~$past(data_o)) == '0);
endmodule

bind otp_seq_array otp_seq_array_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .step_i    (step_i),
  .oe_ni     (oe_ni),
  .size_sel_i(size_sel_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .addr_q    (addr_q)
);

// File: tb/sim_otp_seq_array.sv
`timescale 1ns/1ps
module sim_otp_seq_array;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       step_i = 1'b0;
  logic       oe_ni = 1'b1;
  logic       pgm_ni = 1'b1;
  logic [1:0] size_sel_i = 2'd3;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe_o;

  int total = 0;
  int bad = 0;
  string cur_req = "R9";

  always #2 clk_i = ~clk_i;

  otp_seq_array u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .step_i(step_i),
    .oe_ni(oe_ni), .pgm_ni(pgm_ni), .size_sel_i(size_sel_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // behavioural reference
  logic [7:0] ref_mem [int];
  int         ref_addr;
  logic       step_prev, pgm_prev;
  logic [7:0] ref_wval;

  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_mem.delete();
      ref_addr = 0; step_prev = 1'b0; pgm_prev = 1'b1; ref_wval = 8'hFF;
    end else begin
      int last;
      last = (512 << size_sel_i) - 1;
      if (!pgm_ni && pgm_prev) ref_wval = data_i;
      if (pgm_ni && !pgm_prev) ref_mem[ref_addr] = ref_rd(ref_addr) & ref_wval;
      if (clear_i) ref_addr = 0;
      else if (step_i && !step_prev) ref_addr = (ref_addr >= last) ? 0 : ref_addr + 1;
      step_prev = step_i;
      pgm_prev = pgm_ni;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [7:0] exp_d;
      exp_d = oe_ni ? 8'h00 : ref_rd(ref_addr);
      total++;
      if (data_oe_o !== !oe_ni || data_o !== exp_d) begin
        bad++;
        $display("FAIL %s cycle compare: oe=%b data=%h expected oe=%b data=%h",
                 cur_req, data_oe_o, data_o, !oe_ni, exp_d);
      end
    end
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step_n(int n);
    for (int i = 0; i < n; i++) begin
      step_i = 1'b1; tick(); step_i = 1'b0; tick();
    end
  endtask

  task automatic do_clear();
    clear_i = 1'b1; tick(); clear_i = 1'b0; tick();
  endtask

  task automatic prog(logic [7:0] v);
    data_i = v; pgm_ni = 1'b0; tick(); tick(); pgm_ni = 1'b1; tick();
  endtask

  task automatic read_chk(string req, logic [7:0] exp);
    oe_ni = 1'b0; @(negedge clk_i);
    chk(req, data_o, exp);
    chk(req, {7'd0, data_oe_o}, 8'h01);
    tick(); oe_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R9: reset state
    #5;
    chk("R9", {7'd0, data_oe_o}, 8'h00);
    chk("R9", data_o, 8'h00);
    tick(); rst_ni = 1'b1; tick();
    read_chk("R9", 8'hFF);

    cur_req = "R6";
    prog(8'hA5);
    read_chk("R6", 8'hA5);

    cur_req = "R7";
    step_n(1);
    prog(8'hF0);
    read_chk("R7", 8'hF0);
    prog(8'hFF);
    read_chk("R7", 8'hF0);
    prog(8'h3F);
    read_chk("R7", 8'h30);

    // R2: hold step high for several cycles, one advance
    cur_req = "R2";
    step_i = 1'b1; tick(); tick(); tick(); step_i = 1'b0; tick();
    prog(8'h12);
    read_chk("R2", 8'h12);
    step_n(1);
    read_chk("R2", 8'hFF);

    // R6: data changes during strobe low are ignored
    cur_req = "R6";
    data_i = 8'h81; pgm_ni = 1'b0; tick();
    data_i = 8'h00; tick(); tick(); pgm_ni = 1'b1; tick();
    read_chk("R6", 8'h81);

    // R4: bus released while programming with OE high
    cur_req = "R4";
    step_n(1);
    data_i = 8'h5A; pgm_ni = 1'b0; @(negedge clk_i);
    chk("R4", {7'd0, data_oe_o}, 8'h00);
    chk("R4", data_o, 8'h00);
    tick(); pgm_ni = 1'b1; tick();
    read_chk("R5", 8'h5A);

    // R1: clear wins over a step in the same cycle
    cur_req = "R1";
    clear_i = 1'b1; step_i = 1'b1; tick(); clear_i = 1'b0; step_i = 1'b0; tick();
    read_chk("R1", 8'hA5);

    // R8: revisit by clear then count
    cur_req = "R8";
    step_n(1);
    read_chk("R8", 8'h30);
    step_n(1);
    read_chk("R8", 8'h12);

    // R3: wrap in 512-byte span
    cur_req = "R3";
    size_sel_i = 2'd0;
    do_clear();
    step_n(512);
    read_chk("R3", 8'hA5);

    // R3: shrink span while above its last address
    size_sel_i = 2'd3;
    do_clear();
    step_n(600);
    read_chk("R3", 8'hFF);
    size_sel_i = 2'd0;
    step_n(1);
    read_chk("R3", 8'hA5);

    // R3: full 4 KB wrap, contents kept (R8)
    size_sel_i = 2'd3;
    do_clear();
    step_n(4095);
    prog(8'h0C);
    read_chk("R3", 8'h0C);
    step_n(1);
    read_chk("R8", 8'hA5);

    // R5: bit order via single-bit pattern
    cur_req = "R5";
    step_n(5);
    prog(8'hFE);
    read_chk("R5", 8'hFE);

    tick(); tick();
    finish_run();
  end
endmodule